// File: doc/BRIEF.md
# Parallel Issue Cross-Path Legality Checker

This block inspects one group of instructions issued together on a datapath with two register-file sides (A and B) and decides whether the group respects the routing limits between the sides. Each of up to `N_SLOTS` issue slots carries a small descriptor. The descriptor gives the functional-unit kind, the side the unit sits on, the side of its destination, the side of the source that may be routed across, and a cross-route request flag. For memory units it also gives the side of the address pointer and the side of the transferred data. A condition-register side is also accepted per slot, but it never affects routing.

The verdict is produced combinationally as a single legal flag plus one violation bit per rule. A registered copy of both is captured whenever the issue strobe `pkt_valid` is high. Issue logic uses the combinational result to stall or split a group, and the registered copy to report what was actually issued. Binary instruction decoding and the data movement itself are handled elsewhere.

Encodings used on the ports: unit kind 0 = logic unit (L), 1 = shift unit (S), 2 = multiply unit (M), 3 = memory unit (D); side 0 = A, 1 = B. Violation vector bit positions are given in the requirements.

Top module: `xpc_pkt_legality`

## Requirements
- R1: An active L, S or M slot whose destination side differs from its unit side sets `viol[0]`.
- R2: For an active L, S or M slot, the cross flag must be 1 exactly when the source side differs from the unit side; any mismatch sets `viol[1]`.
- R3: An active D slot with its cross flag set sets `viol[2]`, because memory units may not use a data cross route.
- R4: If more than one active L, S or M slot on the same unit side has its cross flag set, `viol[3]` is set. One flagged slot on side A together with one on side B is allowed.
- R5: An active D slot whose pointer side differs from its unit side sets `viol[4]`. Its data side may be either side.
- R6: When two or more D slots are active, either every one of them must have its data side different from its unit side, or none may; a mix sets `viol[5]`.
- R7: The condition-register inputs (`slot_cond_use`, `slot_cond_side`) never change `pkt_legal` or `viol`.
- R8: A slot with `slot_active` = 0 contributes to no rule, whatever its other fields hold.
- R9: `pkt_legal` is 1 exactly when `viol` is all zero, in the same cycle as the inputs. On a rising clock edge with `pkt_valid` = 1, `legal_q` and `viol_q` take the current `pkt_legal` and `viol`; otherwise they hold.
- R10: Synchronous reset `rst` sets `legal_q` to 1 and `viol_q` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | Capture strobe for the registered verdict |
| slot_active | input | N_SLOTS | Slot holds an instruction |
| slot_kind | input | 2*N_SLOTS | Unit kind per slot, 2 bits each |
| slot_unit_side | input | N_SLOTS | Side of the unit |
| slot_dst_side | input | N_SLOTS | Destination side (L/S/M) |
| slot_src_side | input | N_SLOTS | Side of the crossable source (L/S/M) |
| slot_xflag | input | N_SLOTS | Cross-route request flag |
| slot_ptr_side | input | N_SLOTS | Address pointer side (D) |
| slot_data_side | input | N_SLOTS | Load/store data side (D) |
| slot_cond_use | input | N_SLOTS | Slot is conditional |
| slot_cond_side | input | N_SLOTS | Condition register side |
| pkt_legal | output | 1 | Combinational verdict |
| viol | output | 6 | Combinational per-rule violations |
| legal_q | output | 1 | Registered verdict |
| viol_q | output | 6 | Registered violations |

## Verification
The assertions assume that every descriptor input is a known 0/1 value on each clock edge after reset, and that the kind field only uses the four listed codes. They also assume that `pkt_valid` is free to toggle in any cycle. The bench drives all inputs from tasks on the falling edge, so each field is always defined. Its random phase uses only the 2-bit kind range, and it changes `pkt_valid` independently of the slot contents, so both the capture and hold paths stay reachable.

// File: rtl/xpc_pkg.sv
package xpc_pkg;

    typedef enum logic [1:0] {
        KIND_L = 2'd0,
        KIND_S = 2'd1,
        KIND_M = 2'd2,
        KIND_D = 2'd3
    } unit_kind_e;

    typedef enum logic {
        SIDE_A = 1'b0,
        SIDE_B = 1'b1
    } side_e;

    localparam int NUM_RULES     = 6;
    localparam int RULE_DST      = 0;
    localparam int RULE_XFLAG    = 1;
    localparam int RULE_D_XPATH  = 2;
    localparam int RULE_OVERUSE  = 3;
    localparam int RULE_PTR      = 4;
    localparam int RULE_MEM_MIX  = 5;

    typedef struct packed {
        logic       active;
        unit_kind_e kind;
        side_e      unit_side;
        side_e      dst_side;
        side_e      src_side;
        logic       xflag;
        side_e      ptr_side;
        side_e      data_side;
    } slot_desc_t;

    typedef struct packed {
        logic dst_bad;
        logic xflag_bad;
        logic d_xpath;
        logic ptr_bad;
        logic xread_a;
        logic xread_b;
        logic mem_acc;
        logic mem_cross;
    } slot_flags_t;

    function automatic logic uses_data_route(unit_kind_e k);
        return k != KIND_D;
    endfunction

endpackage

// File: rtl/xpc_slot_check.sv
module xpc_slot_check
    import xpc_pkg::*;
(
    input  slot_desc_t  desc,
    output slot_flags_t flags
);
    logic data_unit;
    logic mem_unit;
    logic src_remote;

    always_comb begin
        data_unit  = desc.active && uses_data_route(desc.kind);
        mem_unit   = desc.active && (desc.kind == KIND_D);
        src_remote = (desc.src_side != desc.unit_side);

        flags.dst_bad   = data_unit && (desc.dst_side != desc.unit_side);
        flags.xflag_bad = data_unit && (desc.xflag != src_remote);
        flags.d_xpath   = mem_unit && desc.xflag;
        flags.ptr_bad   = mem_unit && (desc.ptr_side != desc.unit_side);
        flags.xread_a   = data_unit && desc.xflag && (desc.unit_side == SIDE_A);
        flags.xread_b   = data_unit && desc.xflag && (desc.unit_side == SIDE_B);
        flags.mem_acc   = mem_unit;
        flags.mem_cross = mem_unit && (desc.data_side != desc.unit_side);
    end
endmodule

// File: rtl/xpc_packet_rules.sv
module xpc_packet_rules
    import xpc_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input  slot_flags_t          flags [N_SLOTS],
    output logic [NUM_RULES-1:0] viol
);
    localparam int CW = $clog2(N_SLOTS + 1);

    logic [CW-1:0] cnt_a;
    logic [CW-1:0] cnt_b;
    logic          any_mem_cross;
    logic          any_mem_local;
    logic          any_dst;
    logic          any_xflag;
    logic          any_dx;
    logic          any_ptr;

    always_comb begin
        cnt_a         = '0;
        cnt_b         = '0;
        any_mem_cross = 1'b0;
        any_mem_local = 1'b0;
        any_dst       = 1'b0;
        any_xflag     = 1'b0;
        any_dx        = 1'b0;
        any_ptr       = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            cnt_a         = cnt_a + CW'(flags[i].xread_a);
            cnt_b         = cnt_b + CW'(flags[i].xread_b);
            any_mem_cross = any_mem_cross | flags[i].mem_cross;
            any_mem_local = any_mem_local | (flags[i].mem_acc & ~flags[i].mem_cross);
            any_dst       = any_dst | flags[i].dst_bad;
            any_xflag     = any_xflag | flags[i].xflag_bad;
            any_dx        = any_dx | flags[i].d_xpath;
            any_ptr       = any_ptr | flags[i].ptr_bad;
        end
        viol               = '0;
        viol[RULE_DST]     = any_dst;
        viol[RULE_XFLAG]   = any_xflag;
        viol[RULE_D_XPATH] = any_dx;
        viol[RULE_OVERUSE] = (cnt_a > CW'(1)) || (cnt_b > CW'(1));
        viol[RULE_PTR]     = any_ptr;
        viol[RULE_MEM_MIX] = any_mem_cross && any_mem_local;
    end
endmodule

// File: rtl/xpc_verdict_reg.sv
module xpc_verdict_reg
    import xpc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 capture,
    input  logic                 legal_d,
    input  logic [NUM_RULES-1:0] viol_d,
    output logic                 legal_r,
    output logic [NUM_RULES-1:0] viol_r
);
    always_ff @(posedge clk) begin
        if (rst) begin
            legal_r <= 1'b1;
            viol_r  <= '0;
        end else if (capture) begin
            legal_r <= legal_d;
            viol_r  <= viol_d;
        end
    end
endmodule

// File: rtl/xpc_pkt_legality.sv
module xpc_pkt_legality
    import xpc_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   pkt_valid,
    input  logic [N_SLOTS-1:0]     slot_active,
    input  logic [2*N_SLOTS-1:0]   slot_kind,
    input  logic [N_SLOTS-1:0]     slot_unit_side,
    input  logic [N_SLOTS-1:0]     slot_dst_side,
    input  logic [N_SLOTS-1:0]     slot_src_side,
    input  logic [N_SLOTS-1:0]     slot_xflag,
    input  logic [N_SLOTS-1:0]     slot_ptr_side,
    input  logic [N_SLOTS-1:0]     slot_data_side,
    input  logic [N_SLOTS-1:0]     slot_cond_use,
    input  logic [N_SLOTS-1:0]     slot_cond_side,
    output logic                   pkt_legal,
    output logic [NUM_RULES-1:0]   viol,
    output logic                   legal_q,
    output logic [NUM_RULES-1:0]   viol_q
);
    slot_desc_t  desc  [N_SLOTS];
    slot_flags_t flags [N_SLOTS];

    // Condition registers are read through their own ports, never a cross route.
    logic unused_cond;
    assign unused_cond = ^{slot_cond_use, slot_cond_side};

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign desc[g].active    = slot_active[g];
        assign desc[g].kind      = unit_kind_e'(slot_kind[2*g +: 2]);
        assign desc[g].unit_side = side_e'(slot_unit_side[g]);
        assign desc[g].dst_side  = side_e'(slot_dst_side[g]);
        assign desc[g].src_side  = side_e'(slot_src_side[g]);
        assign desc[g].xflag     = slot_xflag[g];
        assign desc[g].ptr_side  = side_e'(slot_ptr_side[g]);
        assign desc[g].data_side = side_e'(slot_data_side[g]);

        xpc_slot_check u_slot (
            .desc  (desc[g]),
            .flags (flags[g])
        );
    end

    xpc_packet_rules #(.N_SLOTS(N_SLOTS)) u_rules (
        .flags (flags),
        .viol  (viol)
    );

    assign pkt_legal = ~|viol;

    xpc_verdict_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .capture (pkt_valid),
        .legal_d (pkt_legal),
        .viol_d  (viol),
        .legal_r (legal_q),
        .viol_r  (viol_q)
    );
endmodule

// File: rtl/xpc_pkt_legality_chk.sv
module xpc_pkt_legality_chk
    import xpc_pkg::*;
#(
    parameter int N_SLOTS = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pkt_valid,
    input logic [N_SLOTS-1:0]   slot_active,
    input logic [2*N_SLOTS-1:0] slot_kind,
    input logic [N_SLOTS-1:0]   slot_unit_side,
    input logic [N_SLOTS-1:0]   slot_dst_side,
    input logic [N_SLOTS-1:0]   slot_xflag,
    input logic [N_SLOTS-1:0]   slot_ptr_side,
    input logic                 pkt_legal,
    input logic [NUM_RULES-1:0] viol,
    input logic                 legal_q,
    input logic [NUM_RULES-1:0] viol_q
);
    logic dst_seen;
    logic dx_seen;
    logic ptr_seen;

    always_comb begin
        dst_seen = 1'b0;
        dx_seen  = 1'b0;
        ptr_seen = 1'b0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (slot_active[i] && slot_kind[2*i +: 2] != 2'd3 &&
                slot_dst_side[i] != slot_unit_side[i])
                dst_seen = 1'b1;
            if (slot_active[i] && slot_kind[2*i +: 2] == 2'd3 && slot_xflag[i])
                dx_seen = 1'b1;
            if (slot_active[i] && slot_kind[2*i +: 2] == 2'd3 &&
                slot_ptr_side[i] != slot_unit_side[i])
                ptr_seen = 1'b1;
        end
    end

    AST_DST_SIDE: assert property (@(posedge clk) disable iff (rst) viol[RULE_DST] == dst_seen); // R1
    AST_MEM_NO_XPATH: assert property (@(posedge clk) disable iff (rst) viol[RULE_D_XPATH] == dx_seen); // R3
    AST_PTR_SIDE: assert property (@(posedge clk) disable iff (rst) viol[RULE_PTR] == ptr_seen); // R5
    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst) pkt_valid |=> (legal_q == $past(pkt_legal)) && (viol_q == $past(viol))); // R9
    AST_HOLD: assert property (@(posedge clk) disable iff (rst) !pkt_valid |=> $stable(legal_q) && $stable(viol_q)); // R9
    AST_Q_CONSISTENT: assert property (@(posedge clk) disable iff (rst) legal_q == (viol_q == '0)); // R9
    AST_RESET_STATE: assert property (@(posedge clk) rst |=> legal_q && (viol_q == '0)); // R10
endmodule

bind xpc_pkt_legality xpc_pkt_legality_chk #(.N_SLOTS(N_SLOTS)) u_chk (.*);

// File: tb/tb_xpc_pkt_legality.sv
module tb_xpc_pkt_legality;
    localparam int N = 8;
    localparam int NR = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pkt_valid = 1'b0;
    logic [N-1:0]   s_act = '0;
    logic [2*N-1:0] s_kind = '0;
    logic [N-1:0]   s_us = '0, s_ds = '0, s_ss = '0, s_xf = '0;
    logic [N-1:0]   s_ps = '0, s_dts = '0, s_cu = '0, s_cs = '0;
    logic           pkt_legal, legal_q;
    logic [NR-1:0]  viol, viol_q;

    int total = 0;
    int bad = 0;
    logic          exp_lq;
    logic [NR-1:0] exp_vq;
    string rname [NR] = '{"R1", "R2", "R3", "R4", "R5", "R6"};

    always #10 clk = ~clk;

    xpc_pkt_legality #(.N_SLOTS(N)) dut (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid),
        .slot_active(s_act), .slot_kind(s_kind), .slot_unit_side(s_us),
        .slot_dst_side(s_ds), .slot_src_side(s_ss), .slot_xflag(s_xf),
        .slot_ptr_side(s_ps), .slot_data_side(s_dts),
        .slot_cond_use(s_cu), .slot_cond_side(s_cs),
        .pkt_legal(pkt_legal), .viol(viol), .legal_q(legal_q), .viol_q(viol_q)
    );

    // Behavioural reference: rules evaluated straight from the requirement text.
    function automatic logic [NR-1:0] model();
        logic [NR-1:0] v = '0;
        int xa = 0, xb = 0, mcross = 0, mlocal = 0;
        for (int i = 0; i < N; i++) begin
            int k = int'(s_kind[2*i +: 2]);
            if (!s_act[i]) continue;                       // R8
            if (k == 3) begin
                if (s_xf[i]) v[2] = 1'b1;                  // R3
                if (s_ps[i] != s_us[i]) v[4] = 1'b1;       // R5
                if (s_dts[i] != s_us[i]) mcross++; else mlocal++;
            end else begin
                if (s_ds[i] != s_us[i]) v[0] = 1'b1;       // R1
                if (s_xf[i] != (s_ss[i] != s_us[i])) v[1] = 1'b1; // R2
                if (s_xf[i]) begin
                    if (s_us[i]) xb++; else xa++;
                end
            end
        end
        if (xa > 1 || xb > 1) v[3] = 1'b1;                 // R4
        if (mcross > 0 && mlocal > 0) v[5] = 1'b1;         // R6
        return v;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_pkt();
        s_act = '0; s_kind = '0; s_us = '0; s_ds = '0; s_ss = '0;
        s_xf = '0; s_ps = '0; s_dts = '0; s_cu = '0; s_cs = '0;
    endtask

    task automatic put(int i, int k, bit us, bit ds, bit ss, bit xf, bit ps, bit dts);
        s_act[i] = 1'b1; s_kind[2*i +: 2] = 2'(k); s_us[i] = us; s_ds[i] = ds;
        s_ss[i] = ss; s_xf[i] = xf; s_ps[i] = ps; s_dts[i] = dts;
    endtask

    // Inputs are set just after a falling edge; combinational check 5 ns later,
    // registered check on the next falling edge.
    task automatic step(string tag, logic [NR-1:0] want_v);
        logic [NR-1:0] mv;
        #5;
        mv = model();
        if (want_v !== mv) begin
            total++; bad++;
            $display("FAIL %s bench model actual=%0h expected=%0h", tag, mv, want_v);
        end
        for (int b = 0; b < NR; b++) check(rname[b], 32'(viol[b]), 32'(mv[b]));
        check({"R9 ", tag}, 32'(pkt_legal), 32'(mv == '0));
        @(posedge clk);
        if (pkt_valid) begin
            exp_lq = (mv == '0);
            exp_vq = mv;
        end
        @(negedge clk);
        check("R9 legal_q", 32'(legal_q), 32'(exp_lq));
        check("R9 viol_q", 32'(viol_q), 32'(exp_vq));
    endtask

    initial begin
        #(20 * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        pkt_valid = 1'b1;
        put(0, 0, 0, 1, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R10 legal_q", 32'(legal_q), 32'd1);
        check("R10 viol_q", 32'(viol_q), 32'd0);
        exp_lq = 1'b1; exp_vq = '0;

        clear_pkt(); step("empty", 6'h00);
        clear_pkt(); put(0, 0, 0, 1, 0, 0, 0, 0); step("R1 dst other side", 6'h01);
        clear_pkt(); put(1, 1, 1, 1, 0, 0, 0, 0); step("R2 remote src no flag", 6'h02);
        clear_pkt(); put(1, 2, 0, 0, 0, 1, 0, 0); step("R2 flag local src", 6'h02);
        clear_pkt(); put(2, 3, 0, 0, 0, 1, 0, 0); step("R3 mem unit flag", 6'h04);
        clear_pkt(); put(0, 1, 0, 0, 1, 1, 0, 0); put(3, 0, 0, 0, 1, 1, 0, 0);
        step("R4 two reads side A", 6'h08);
        clear_pkt(); put(0, 1, 1, 1, 0, 1, 0, 0); put(3, 2, 1, 1, 0, 1, 0, 0);
        step("R4 two reads side B", 6'h08);
        clear_pkt(); put(0, 1, 0, 0, 1, 1, 0, 0); put(3, 0, 1, 1, 0, 1, 0, 0);
        step("R4 one per side", 6'h00);
        clear_pkt(); put(4, 3, 1, 0, 0, 0, 0, 1); step("R5 pointer other side", 6'h10);
        clear_pkt(); put(4, 3, 1, 0, 0, 0, 1, 0); step("R5 data other side ok", 6'h00);
        clear_pkt(); put(4, 3, 0, 0, 0, 0, 0, 1); put(5, 3, 1, 0, 0, 0, 1, 1);
        step("R6 mixed crossing", 6'h20);
        clear_pkt(); put(4, 3, 0, 0, 0, 0, 0, 1); put(5, 3, 1, 0, 0, 0, 1, 0);
        step("R6 both cross", 6'h00);
        clear_pkt(); put(4, 3, 0, 0, 0, 0, 0, 0); put(5, 3, 1, 0, 0, 0, 1, 1);
        step("R6 neither cross", 6'h00);
        clear_pkt(); put(0, 0, 0, 0, 1, 1, 0, 0); s_cu = '1; s_cs = 8'hA5;
        step("R7 conditions opposite", 6'h00);
        s_cs = 8'h5A; step("R7 conditions flipped", 6'h00);
        clear_pkt(); s_kind = '1; s_xf = '1; s_ds = '1; s_ps = '1;
        put(0, 2, 1, 1, 1, 0, 0, 0); step("R8 inactive garbage", 6'h00);
        clear_pkt(); put(0, 0, 0, 1, 0, 0, 0, 0); step("R9 capture illegal", 6'h01);
        pkt_valid = 1'b0;
        clear_pkt(); step("R9 hold", 6'h00);
        put(2, 3, 0, 0, 0, 1, 0, 0); step("R9 hold again", 6'h04);
        pkt_valid = 1'b1;

        for (int n = 0; n < 3000; n++) begin
            clear_pkt();
            pkt_valid = ($urandom_range(0, 3) != 0);
            for (int i = 0; i < N; i++) begin
                bit us = 1'($urandom);
                bit ss = ($urandom_range(0, 3) == 0) ? ~us : us;
                s_act[i] = ($urandom_range(0, 2) == 0);
                s_kind[2*i +: 2] = 2'($urandom);
                s_us[i] = us;
                s_ds[i] = ($urandom_range(0, 9) == 0) ? ~us : us;
                s_ss[i] = ss;
                s_xf[i] = ($urandom_range(0, 9) == 0) ? (ss == us) : (ss != us);
                s_ps[i] = ($urandom_range(0, 9) == 0) ? ~us : us;
                s_dts[i] = 1'($urandom);
                s_cu[i] = 1'($urandom);
                s_cs[i] = 1'($urandom);
            end
            step("random", model());
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule